// File: doc/BRIEF.md
# SPI Command Register Front End for a CAN Controller

This block is the host-facing register layer of a small CAN controller. A host drives SPI mode 0 with 8-bit words, most significant bit first. The first byte inside each chip-select window is a command byte. That byte selects one of five actions: a register write, a register read, a one-byte controller reset, a stream of bytes into the transmit buffer, or a read of one received frame entry. Read data comes back on MISO in the byte that follows the command.

The SPI pins are brought into the system clock domain by a synchronizer. The system clock has to run several times faster than SCLK. The CAN protocol engine is not part of this block, and it connects through plain side ports:
- configuration outputs for mode, transmitter enable and the two bit-timing bytes;
- sticky event inputs for error and interrupt flags;
- the two error counters and the message status byte;
- a receive-entry port with a pop strobe;
- a transmit byte strobe.

Error flags and interrupt flags are sticky, and reading them clears them. An interrupt line is asserted while any enabled interrupt flag is pending.

Top module: `canspi_frontend`

## Requirements
- R1: After reset, control 0 reads 0x80 (mode field bits 7:5 = 4, init), status reads 0x82 with tx_idle_i=1, rx_avail_i=0 and bus_stat_i=0, control 1 and both bit-timing registers read 0x00, both flag registers read 0x00, and irq_o is low.
- R2: Write commands 0x14, 0x16, 0x18, 0x1A and 0x1C load control 0, control 1, bit timing 0, bit timing 1 and interrupt enable from the second byte. Read commands 0xD2, 0xD4, 0xD6 and 0xD8 return the first four of these. mode_o equals control 0 bits 7:5 (0 normal, 1 loopback, 2 monitor, 3 sleep, 4 init), tx_en_o equals control 1 bit 7, and bt0_o and bt1_o mirror the timing registers.
- R3: MISO returns 0x00 during the command byte. A register read returns its value in the next byte, MSB first, and 0x00 in every later byte.
- R4: Command 0xE2 returns status {tx_idle_i, bus_stat_i[4:0], ~rx_avail_i, 1'b0}. Command 0xDA returns msg_stat_i, 0xEA returns rec_i and 0xEC returns tec_i.
- R5: Error flags accumulate err_set_i bits. Command 0xDC returns the flags and clears them when the command byte completes. A bit that is set in the clearing cycle or later survives.
- R6: Interrupt flags accumulate int_set_i bits masked by interrupt enable. Command 0xDE returns and clears them. irq_o is high exactly when a flag is pending.
- R7: One-byte command 0x56 restores control 0 to 0x80, clears control 1, both bit-timing registers, interrupt enable and interrupt flags, and keeps the error flags.
- R8: Command 0x48 with rx_avail_i=1 pulses rx_pop_o for one cycle and returns the 14 entry bytes, with byte k taken from rx_entry_i[8k+7:8k] and byte 0 first, followed by 0x00. With rx_avail_i=0 it returns only 0x00 and does not pop.
- R9: Command 0x12 emits every following byte as a one-cycle tx_valid_o strobe, with that byte on tx_byte_o.
- R10: An unknown command byte changes no register and reads 0x00. Bytes after the data byte of a register write are ignored.
- R11: When chip select deasserts, any partial byte is discarded and the next window starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk_i | input | 1 | SPI serial clock (mode 0) |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI data from host |
| spi_miso_o | output | 1 | SPI data to host, low when deselected |
| tx_idle_i | input | 1 | Transmit buffer empty, status bit 7 |
| rx_avail_i | input | 1 | Receive FIFO holds an entry |
| rx_entry_i | input | 112 | Head receive entry, byte k at bits 8k+7:8k |
| rx_pop_o | output | 1 | One-cycle pop of the head receive entry |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_byte_o | output | 8 | Transmit byte value |
| msg_stat_i | input | 8 | Message status byte |
| bus_stat_i | input | 5 | Engine status bits for status bits 6:2 |
| err_set_i | input | 8 | Error flag set events |
| int_set_i | input | 8 | Interrupt flag set events |
| tec_i | input | 8 | Transmit error counter |
| rec_i | input | 8 | Receive error counter |
| mode_o | output | 3 | Operating mode field |
| tx_en_o | output | 1 | Transmitter enable |
| bt0_o | output | 8 | Bit timing byte 0 |
| bt1_o | output | 8 | Bit timing byte 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is an error event that arrives in the same few system cycles as the clear caused by reading the error flags. The clear happens a synchronizer delay after the eighth SCLK rise of the command byte, so its exact cycle is hidden. The bench holds err_set_i asserted from that eighth rise across the following SCLK half period. Because of this, the set event straddles the clearing cycle whatever the synchronizer latency. The bench then expects the read to return the earlier flag together with the new one, and a second read to return only the new one. Reset-retained error flags and partial bytes cut off by chip select are also reached through directed windows. Configuration read-back is reached through a seeded random stream of writes, and unknown commands are mixed into that stream.

// File: rtl/canspi_pkg.sv
package canspi_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // command bytes
    localparam byte_t OP_WR_CTL0 = 8'h14;
    localparam byte_t OP_WR_CTL1 = 8'h16;
    localparam byte_t OP_WR_BT0  = 8'h18;
    localparam byte_t OP_WR_BT1  = 8'h1A;
    localparam byte_t OP_WR_IEN  = 8'h1C;
    localparam byte_t OP_WR_TXQ  = 8'h12;
    localparam byte_t OP_RD_CTL0 = 8'hD2;
    localparam byte_t OP_RD_CTL1 = 8'hD4;
    localparam byte_t OP_RD_BT0  = 8'hD6;
    localparam byte_t OP_RD_BT1  = 8'hD8;
    localparam byte_t OP_RD_MSG  = 8'hDA;
    localparam byte_t OP_RD_ERR  = 8'hDC;
    localparam byte_t OP_RD_INT  = 8'hDE;
    localparam byte_t OP_RD_STAT = 8'hE2;
    localparam byte_t OP_RD_REC  = 8'hEA;
    localparam byte_t OP_RD_TEC  = 8'hEC;
    localparam byte_t OP_RD_RXQ  = 8'h48;
    localparam byte_t OP_RESET   = 8'h56;

    typedef enum logic [2:0] {
        MODE_NORMAL  = 3'd0,
        MODE_LOOP    = 3'd1,
        MODE_MONITOR = 3'd2,
        MODE_SLEEP   = 3'd3,
        MODE_INIT    = 3'd4
    } mode_e;

    // what the bytes after the command byte mean
    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_WRITE,
        CMD_TXQ,
        CMD_RXQ,
        CMD_DONE
    } cmd_e;

    typedef enum logic [2:0] {
        REG_CTL0,
        REG_CTL1,
        REG_BT0,
        REG_BT1,
        REG_IEN
    } wsel_e;

    typedef struct packed {
        byte_t ctl0;
        byte_t ctl1;
        byte_t bt0;
        byte_t bt1;
        byte_t ien;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        ctl0: {MODE_INIT, 5'b0},
        ctl1: 8'h00,
        bt0:  8'h00,
        bt1:  8'h00,
        ien:  8'h00
    };

    // returns 1 when op is a register write command, sel names the target
    function automatic logic wr_decode(input byte_t op, output wsel_e sel);
        wr_decode = 1'b1;
        sel = REG_CTL0;
        case (op)
            OP_WR_CTL0: sel = REG_CTL0;
            OP_WR_CTL1: sel = REG_CTL1;
            OP_WR_BT0:  sel = REG_BT0;
            OP_WR_BT1:  sel = REG_BT1;
            OP_WR_IEN:  sel = REG_IEN;
            default:    wr_decode = 1'b0;
        endcase
    endfunction

    function automatic cfg_t cfg_update(input cfg_t c, input wsel_e s, input byte_t d);
        cfg_t r;
        r = c;
        case (s)
            REG_CTL0: r.ctl0 = d;
            REG_CTL1: r.ctl1 = d;
            REG_BT0:  r.bt0  = d;
            REG_BT1:  r.bt1  = d;
            default:  r.ien  = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/canspi_insync.sv
module canspi_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sel_o,
    output logic rise_o,
    output logic fall_o,
    output logic mosi_o
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] mosi_p;
    logic              sclk_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    sclk_p[g] <= 1'b0;
                    cs_p[g]   <= 1'b1;
                    mosi_p[g] <= 1'b0;
                end else if (g == 0) begin
                    sclk_p[g] <= sclk_i;
                    cs_p[g]   <= cs_n_i;
                    mosi_p[g] <= mosi_i;
                end else begin
                    sclk_p[g] <= sclk_p[(g == 0) ? 0 : g - 1];
                    cs_p[g]   <= cs_p[(g == 0) ? 0 : g - 1];
                    mosi_p[g] <= mosi_p[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_p[TOP];
    end

    assign sel_o  = ~cs_p[TOP];
    assign rise_o = sel_o &  sclk_p[TOP] & ~sclk_q;
    assign fall_o = sel_o & ~sclk_p[TOP] &  sclk_q;
    assign mosi_o = mosi_p[TOP];

endmodule

// File: rtl/canspi_shifter.sv
module canspi_shifter
    import canspi_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_i,
    input  logic  rise_i,
    input  logic  fall_i,
    input  logic  mosi_i,
    input  byte_t reply_i,
    output logic  byte_done_o,
    output byte_t byte_o,
    output logic  miso_bit_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] in_q;
    byte_t             out_q;
    logic              load_pend;

    assign byte_done_o = rise_i && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign byte_o      = {in_q, mosi_i};
    assign miso_bit_o  = out_q[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst || !sel_i) begin
            bit_cnt   <= '0;
            in_q      <= '0;
            out_q     <= '0;
            load_pend <= 1'b0;
        end else begin
            if (rise_i) begin
                in_q    <= {in_q[BYTE_W-3:0], mosi_i};
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_done_o) load_pend <= 1'b1;
            end
            if (fall_i) begin
                if (load_pend) begin
                    out_q     <= reply_i;
                    load_pend <= 1'b0;
                end else begin
                    out_q <= {out_q[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/canspi_regs.sv
module canspi_regs
    import canspi_pkg::*;
#(
    parameter int ENTRY_BYTES = 14
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          sel_i,
    input  logic                          byte_done_i,
    input  byte_t                         byte_i,
    output byte_t                         reply_o,
    input  logic                          tx_idle_i,
    input  logic                          rx_avail_i,
    input  logic [ENTRY_BYTES*BYTE_W-1:0] rx_entry_i,
    input  byte_t                         msg_stat_i,
    input  logic [4:0]                    bus_stat_i,
    input  byte_t                         err_set_i,
    input  byte_t                         int_set_i,
    input  byte_t                         tec_i,
    input  byte_t                         rec_i,
    output cfg_t                          cfg_o,
    output logic                          irq_o,
    output logic                          rx_pop_o,
    output logic                          tx_valid_o,
    output byte_t                         tx_byte_o
);
    localparam int ENTRY_W = ENTRY_BYTES * BYTE_W;

    cfg_t               cfg_q;
    byte_t              err_q;
    byte_t              intf_q;
    byte_t              reply_q;
    cmd_e               cmd_q;
    wsel_e              wsel_q;
    logic               first_q;
    logic [ENTRY_W-1:0] ent_q;
    logic               pop_q;
    logic               txv_q;
    byte_t              txb_q;

    byte_t status_w;
    byte_t rd_val;
    logic  rd_hit;
    logic  wr_hit;
    wsel_e wsel_n;
    logic  op_start;
    logic  data_byte;
    logic  clr_err;
    logic  clr_int;
    logic  mreset;

    assign status_w  = {tx_idle_i, bus_stat_i, ~rx_avail_i, 1'b0};
    assign op_start  = byte_done_i &  first_q;
    assign data_byte = byte_done_i & ~first_q;
    assign clr_err   = op_start && (byte_i == OP_RD_ERR);
    assign clr_int   = op_start && (byte_i == OP_RD_INT);
    assign mreset    = op_start && (byte_i == OP_RESET);

    always_comb begin
        wr_hit = wr_decode(byte_i, wsel_n);
    end

    always_comb begin
        rd_hit = 1'b1;
        rd_val = '0;
        case (byte_i)
            OP_RD_CTL0: rd_val = cfg_q.ctl0;
            OP_RD_CTL1: rd_val = cfg_q.ctl1;
            OP_RD_BT0:  rd_val = cfg_q.bt0;
            OP_RD_BT1:  rd_val = cfg_q.bt1;
            OP_RD_MSG:  rd_val = msg_stat_i;
            OP_RD_ERR:  rd_val = err_q;
            OP_RD_INT:  rd_val = intf_q;
            OP_RD_STAT: rd_val = status_w;
            OP_RD_REC:  rd_val = rec_i;
            OP_RD_TEC:  rd_val = tec_i;
            default:    rd_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= CFG_RESET;
            err_q   <= '0;
            intf_q  <= '0;
            reply_q <= '0;
            cmd_q   <= CMD_IDLE;
            wsel_q  <= REG_CTL0;
            first_q <= 1'b1;
            ent_q   <= '0;
            pop_q   <= 1'b0;
            txv_q   <= 1'b0;
            txb_q   <= '0;
        end else begin
            pop_q  <= 1'b0;
            txv_q  <= 1'b0;
            // sticky flags: an event in the clearing cycle is kept
            err_q  <= (clr_err ? '0 : err_q) | err_set_i;
            intf_q <= ((clr_int || mreset) ? '0 : intf_q) | (int_set_i & cfg_q.ien);

            if (!sel_i) begin
                first_q <= 1'b1;
                cmd_q   <= CMD_IDLE;
                reply_q <= '0;
                ent_q   <= '0;
            end else if (op_start) begin
                first_q <= 1'b0;
                reply_q <= '0;
                ent_q   <= '0;
                cmd_q   <= CMD_DONE;
                if (wr_hit) begin
                    cmd_q  <= CMD_WRITE;
                    wsel_q <= wsel_n;
                end else if (byte_i == OP_WR_TXQ) begin
                    cmd_q <= CMD_TXQ;
                end else if (byte_i == OP_RD_RXQ) begin
                    cmd_q <= CMD_RXQ;
                    if (rx_avail_i) begin
                        reply_q <= rx_entry_i[BYTE_W-1:0];
                        ent_q   <= rx_entry_i >> BYTE_W;
                        pop_q   <= 1'b1;
                    end
                end else if (mreset) begin
                    cfg_q <= CFG_RESET;
                end else if (rd_hit) begin
                    reply_q <= rd_val;
                end
            end else if (data_byte) begin
                reply_q <= '0;
                case (cmd_q)
                    CMD_WRITE: begin
                        cfg_q <= cfg_update(cfg_q, wsel_q, byte_i);
                        cmd_q <= CMD_DONE;
                    end
                    CMD_TXQ: begin
                        txv_q <= 1'b1;
                        txb_q <= byte_i;
                    end
                    CMD_RXQ: begin
                        reply_q <= ent_q[BYTE_W-1:0];
                        ent_q   <= ent_q >> BYTE_W;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reply_o    = reply_q;
    assign cfg_o      = cfg_q;
    assign irq_o      = |intf_q;
    assign rx_pop_o   = pop_q;
    assign tx_valid_o = txv_q;
    assign tx_byte_o  = txb_q;

endmodule

// File: rtl/canspi_frontend.sv
module canspi_frontend
    import canspi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_BYTES = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     spi_sclk_i,
    input  logic                     spi_cs_n_i,
    input  logic                     spi_mosi_i,
    output logic                     spi_miso_o,
    input  logic                     tx_idle_i,
    input  logic                     rx_avail_i,
    input  logic [ENTRY_BYTES*8-1:0] rx_entry_i,
    output logic                     rx_pop_o,
    output logic                     tx_valid_o,
    output logic [7:0]               tx_byte_o,
    input  logic [7:0]               msg_stat_i,
    input  logic [4:0]               bus_stat_i,
    input  logic [7:0]               err_set_i,
    input  logic [7:0]               int_set_i,
    input  logic [7:0]               tec_i,
    input  logic [7:0]               rec_i,
    output logic [2:0]               mode_o,
    output logic                     tx_en_o,
    output logic [7:0]               bt0_o,
    output logic [7:0]               bt1_o,
    output logic                     irq_o
);
    logic  sel_w;
    logic  rise_w;
    logic  fall_w;
    logic  mosi_w;
    logic  done_w;
    byte_t byte_w;
    byte_t reply_w;
    logic  bit_w;
    cfg_t  cfg_w;

    canspi_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .sclk_i (spi_sclk_i),
        .cs_n_i (spi_cs_n_i),
        .mosi_i (spi_mosi_i),
        .sel_o  (sel_w),
        .rise_o (rise_w),
        .fall_o (fall_w),
        .mosi_o (mosi_w)
    );

    canspi_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .sel_i       (sel_w),
        .rise_i      (rise_w),
        .fall_i      (fall_w),
        .mosi_i      (mosi_w),
        .reply_i     (reply_w),
        .byte_done_o (done_w),
        .byte_o      (byte_w),
        .miso_bit_o  (bit_w)
    );

    canspi_regs #(.ENTRY_BYTES(ENTRY_BYTES)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .sel_i       (sel_w),
        .byte_done_i (done_w),
        .byte_i      (byte_w),
        .reply_o     (reply_w),
        .tx_idle_i   (tx_idle_i),
        .rx_avail_i  (rx_avail_i),
        .rx_entry_i  (rx_entry_i),
        .msg_stat_i  (msg_stat_i),
        .bus_stat_i  (bus_stat_i),
        .err_set_i   (err_set_i),
        .int_set_i   (int_set_i),
        .tec_i       (tec_i),
        .rec_i       (rec_i),
        .cfg_o       (cfg_w),
        .irq_o       (irq_o),
        .rx_pop_o    (rx_pop_o),
        .tx_valid_o  (tx_valid_o),
        .tx_byte_o   (tx_byte_o)
    );

    assign spi_miso_o = ~spi_cs_n_i & bit_w;
    assign mode_o     = cfg_w.ctl0[7:5];
    assign tx_en_o    = cfg_w.ctl1[7];
    assign bt0_o      = cfg_w.bt0;
    assign bt1_o      = cfg_w.bt1;

endmodule

// File: rtl/canspi_frontend_chk.sv
module canspi_frontend_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_pop_o,
    input logic       rx_avail_i,
    input logic       tx_valid_o,
    input logic [2:0] mode_o,
    input logic       irq_o,
    input logic [7:0] int_set_i
);
    // R1: first cycle out of reset shows init mode and no interrupt
    p_reset_init_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mode_o == 3'd4) && !irq_o);

    // R8: a pop only happens when an entry was offered
    p_pop_needs_data_r8: assert property (@(posedge clk) disable iff (rst)
        rx_pop_o |-> $past(rx_avail_i));

    // R8: pop is a single-cycle pulse
    p_pop_single_r8: assert property (@(posedge clk) disable iff (rst)
        rx_pop_o |=> !rx_pop_o);

    // R9: byte strobes never run back to back
    p_txstrobe_single_r9: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o |=> !tx_valid_o);

    // R6: the interrupt line only rises after an interrupt event
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(int_set_i != 8'h00));
endmodule

bind canspi_frontend canspi_frontend_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_pop_o   (rx_pop_o),
    .rx_avail_i (rx_avail_i),
    .tx_valid_o (tx_valid_o),
    .mode_o     (mode_o),
    .irq_o      (irq_o),
    .int_set_i  (int_set_i)
);

// File: tb/canspi_frontend_tb_top.sv
module canspi_frontend_tb_top;
    localparam int HP = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         mosi = 1'b0;
    logic         miso;
    logic         tx_idle = 1'b1;
    logic         rx_avail = 1'b0;
    logic [111:0] rx_entry = '0;
    logic         rx_pop;
    logic         tx_valid;
    logic [7:0]   tx_byte;
    logic [7:0]   msg_stat = 8'h00;
    logic [4:0]   bus_stat = 5'h00;
    logic [7:0]   err_set = 8'h00;
    logic [7:0]   int_set = 8'h00;
    logic [7:0]   tec = 8'h00;
    logic [7:0]   rec = 8'h00;
    logic [2:0]   mode;
    logic         tx_en;
    logic [7:0]   bt0;
    logic [7:0]   bt1;
    logic         irq;

    int total = 0;
    int bad = 0;
    int pops = 0;
    int txn = 0;
    logic [7:0] txcap [16];
    logic [7:0] mo [16];
    logic [7:0] mi [16];
    logic [7:0] err_hold = 8'h00;
    logic [7:0] sh [4];
    logic [7:0] wop [4] = '{8'h14, 8'h16, 8'h18, 8'h1A};
    logic [7:0] rop [4] = '{8'hD2, 8'hD4, 8'hD6, 8'hD8};

    always #4 clk = ~clk;

    canspi_frontend dut_i (
        .clk(clk), .rst(rst), .spi_sclk_i(sclk), .spi_cs_n_i(cs_n),
        .spi_mosi_i(mosi), .spi_miso_o(miso), .tx_idle_i(tx_idle),
        .rx_avail_i(rx_avail), .rx_entry_i(rx_entry), .rx_pop_o(rx_pop),
        .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .msg_stat_i(msg_stat),
        .bus_stat_i(bus_stat), .err_set_i(err_set), .int_set_i(int_set),
        .tec_i(tec), .rec_i(rec), .mode_o(mode), .tx_en_o(tx_en),
        .bt0_o(bt0), .bt1_o(bt1), .irq_o(irq)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (rx_pop) pops <= pops + 1;
            if (tx_valid) begin
                txcap[txn[3:0]] <= tx_byte;
                txn <= txn + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // shifts nbits of mo[] out, MSB first; bits land in mi[]
    task automatic xfer(input int nbits);
        @(negedge clk) cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int k = 0; k < nbits; k++) begin
            mosi = mo[k / 8][7 - (k % 8)];
            repeat (HP) @(negedge clk);
            mi[k / 8][7 - (k % 8)] = miso;
            sclk = 1'b1;
            if (k == 7) err_set = err_hold;
            repeat (HP) @(negedge clk);
            err_set = 8'h00;
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] op, input logic [7:0] v);
        mo[0] = op; mo[1] = v;
        xfer(16);
    endtask

    task automatic rd(input logic [7:0] op, output logic [7:0] v);
        mo[0] = op; mo[1] = 8'h00;
        xfer(16);
        v = mi[1];
    endtask

    task automatic pulse_err(input logic [7:0] v);
        @(negedge clk) err_set = v;
        @(negedge clk) err_set = 8'h00;
    endtask

    task automatic pulse_int(input logic [7:0] v);
        @(negedge clk) int_set = v;
        @(negedge clk) int_set = 8'h00;
    endtask

    function automatic logic [7:0] exp_status(input logic idle, input logic [4:0] bs, input logic av);
        return {idle, bs, ~av, 1'b0};
    endfunction

    function automatic bit known_op(input logic [7:0] v);
        case (v)
            8'h14, 8'h16, 8'h18, 8'h1A, 8'h1C, 8'h12, 8'hD2, 8'hD4, 8'hD6, 8'hD8,
            8'hDA, 8'hDC, 8'hDE, 8'hE2, 8'hEA, 8'hEC, 8'h48, 8'h56: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] v;
        int p0, t0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        chk("R1 mode_o", mode, 4);
        chk("R1 irq_o", irq, 0);
        rd(8'hD2, v); chk("R1 ctl0", v, 8'h80);
        rd(8'hE2, v); chk("R1 status", v, 8'h82);
        rd(8'hD4, v); chk("R1 ctl1", v, 0);
        rd(8'hD6, v); chk("R1 bt0", v, 0);
        rd(8'hD8, v); chk("R1 bt1", v, 0);
        rd(8'hDC, v); chk("R1 errflags", v, 0);
        rd(8'hDE, v); chk("R1 intflags", v, 0);

        // R2 directed writes
        wr(8'h14, 8'h20); chk("R2 mode loopback", mode, 1);
        wr(8'h16, 8'h80); chk("R2 tx_en", tx_en, 1);
        wr(8'h1A, 8'h3C); chk("R2 bt1_o", bt1, 8'h3C);
        rd(8'hD4, v); chk("R2 ctl1 read", v, 8'h80);

        // R3 reply framing
        mo[0] = 8'hD2; mo[1] = 8'h00; mo[2] = 8'h00;
        xfer(24);
        chk("R3 command byte reply", mi[0], 0);
        chk("R3 data byte reply", mi[1], 8'h20);
        chk("R3 trailing byte reply", mi[2], 0);

        // R4 status and counters
        tx_idle = 1'b0; rx_avail = 1'b1; bus_stat = 5'h1F;
        msg_stat = 8'h5A; tec = 8'h91; rec = 8'h13;
        rd(8'hE2, v); chk("R4 status", v, exp_status(1'b0, 5'h1F, 1'b1));
        tx_idle = 1'b1; rx_avail = 1'b0; bus_stat = 5'h05;
        rd(8'hE2, v); chk("R4 status 2", v, exp_status(1'b1, 5'h05, 1'b0));
        rd(8'hDA, v); chk("R4 msg status", v, 8'h5A);
        rd(8'hEC, v); chk("R4 tec", v, 8'h91);
        rd(8'hEA, v); chk("R4 rec", v, 8'h13);
        bus_stat = 5'h00;

        // R5 sticky error flags, clear on read, event during clear survives
        pulse_err(8'h01); pulse_err(8'h04);
        rd(8'hDC, v); chk("R5 accumulate", v, 8'h05);
        rd(8'hDC, v); chk("R5 cleared", v, 0);
        pulse_err(8'h01);
        err_hold = 8'h10;
        rd(8'hDC, v); chk("R5 read during event", v, 8'h11);
        err_hold = 8'h00;
        rd(8'hDC, v); chk("R5 event kept over clear", v, 8'h10);

        // R6 interrupt flags and enable mask
        pulse_int(8'h50);
        chk("R6 masked irq", irq, 0);
        rd(8'hDE, v); chk("R6 masked flags", v, 0);
        wr(8'h1C, 8'h70);
        pulse_int(8'hD0);
        @(negedge clk); chk("R6 irq high", irq, 1);
        rd(8'hDE, v); chk("R6 flags", v, 8'h50);
        chk("R6 irq low after read", irq, 0);
        rd(8'hDE, v); chk("R6 flags cleared", v, 0);

        // R7 master reset keeps error flags
        pulse_err(8'h08);
        pulse_int(8'h40);
        @(negedge clk); chk("R7 irq before reset", irq, 1);
        mo[0] = 8'h56; xfer(8);
        chk("R7 mode init", mode, 4);
        chk("R7 irq cleared", irq, 0);
        chk("R7 tx_en cleared", tx_en, 0);
        chk("R7 bt1 cleared", bt1, 0);
        rd(8'hDC, v); chk("R7 error flags kept", v, 8'h08);
        pulse_int(8'h40);
        @(negedge clk); chk("R7 enable cleared", irq, 0);

        // R8 receive entry read
        for (int k = 0; k < 14; k++) rx_entry[8*k +: 8] = 8'h30 + 8'(k);
        rx_avail = 1'b1;
        p0 = pops;
        mo[0] = 8'h48;
        for (int k = 1; k < 16; k++) mo[k] = 8'h00;
        xfer(128);
        for (int k = 1; k <= 14; k++) chk("R8 entry byte", mi[k], 8'h30 + k - 1);
        chk("R8 byte after entry", mi[15], 0);
        chk("R8 one pop", pops - p0, 1);
        rx_avail = 1'b0;
        p0 = pops;
        xfer(128);
        chk("R8 empty byte0", mi[1], 0);
        chk("R8 empty byte13", mi[14], 0);
        chk("R8 no pop when empty", pops - p0, 0);

        // R9 transmit stream
        t0 = txn;
        mo[0] = 8'h12; mo[1] = 8'hA5; mo[2] = 8'h3C; mo[3] = 8'h0F;
        xfer(32);
        chk("R9 strobe count", txn - t0, 3);
        chk("R9 byte a", txcap[t0[3:0]], 8'hA5);
        chk("R9 byte b", txcap[4'(t0 + 1)], 8'h3C);
        chk("R9 byte c", txcap[4'(t0 + 2)], 8'h0F);

        // R10 unknown command, trailing write bytes
        mo[0] = 8'h18; mo[1] = 8'h11; mo[2] = 8'h22;
        xfer(24);
        chk("R10 extra bytes ignored", bt0, 8'h11);
        mo[0] = 8'h77; mo[1] = 8'hFF; mo[2] = 8'hFF;
        xfer(24);
        chk("R10 unknown reply", mi[1], 0);
        rd(8'hD2, v); chk("R10 ctl0 unchanged", v, 8'h80);
        rd(8'hD6, v); chk("R10 bt0 unchanged", v, 8'h11);

        // R11 partial bytes discarded
        mo[0] = 8'h14; mo[1] = 8'hE0;
        xfer(12);
        chk("R11 partial data", mode, 4);
        mo[0] = 8'h16;
        xfer(5);
        rd(8'hD2, v); chk("R11 fresh window", v, 8'h80);

        // R2 seeded random write/read-back, mixed with unknown commands (R10)
        sh[0] = 8'h80; sh[1] = 8'h00; sh[2] = 8'h11; sh[3] = 8'h00;
        for (int it = 0; it < 30; it++) begin
            int s;
            logic [7:0] d;
            s = $urandom_range(0, 3);
            d = 8'($urandom);
            if (it % 5 == 4) begin
                if (!known_op(d)) begin
                    wr(d, 8'hFF);
                    chk("R10 random unknown reply", mi[1], 0);
                end
            end else begin
                wr(wop[s], d);
                sh[s] = d;
            end
            rd(rop[s], v);
            chk("R2 random readback", v, sh[s]);
            chk("R2 random mode_o", mode, sh[0][7:5]);
            chk("R2 random tx_en_o", tx_en, sh[1][7]);
        end

        summary();
    end
endmodule